// File: doc/BRIEF.md
# Validity-Driven Header Deparser

This block turns a parsed packet back into a byte stream. For each packet it takes one header bundle. The bundle holds five protocol headers, each with its own presence flag. The block then sends out the present headers one after another in a fixed protocol order. After the headers it forwards the packet body, which arrives on a separate byte stream, without changing it. Upstream logic adds a header to the outgoing packet by raising its presence flag and removes one by clearing it. No other control is involved.

Output bytes leave on a valid/ready byte interface with a last marker. The header bundle is taken through its own valid/ready pair. A new bundle is accepted only after the final body byte of the previous packet has left the block. The block does not recompute checksums, does not rewrite length fields and does not pad short frames.

Top module: `hdr_deparser`

## Requirements
- R1: Present headers are sent in this order: Ethernet (14 bytes), MPLS label (4 bytes), IPv4 (20 bytes), TCP (20 bytes), UDP (8 bytes). Presence flag bit 0 selects Ethernet, bit 1 MPLS, bit 2 IPv4, bit 3 TCP and bit 4 UDP.
- R2: A header whose presence flag is 0 adds no bytes. The number of header bytes sent equals the summed lengths of the flagged headers.
- R3: Each header is sent most significant byte first. Bits [W-1:W-8] of a W-bit header bus form its first byte on the wire.
- R4: The body bytes follow the last present header unchanged and in order. `out_last` is high only with the final body byte, which is the byte marked by `pl_last`.
- R5: With all presence flags at 0, the output is the body stream alone.
- R6: While `out_valid` is high and `out_ready` is low, the output byte and `out_last` stay the same. Every byte is sent exactly once. A body byte is consumed only in the cycle it is sent.
- R7: If TCP and UDP are both flagged, both are sent, TCP first, with no error reported.
- R8: `hdr_ready` is high only while no packet is in progress. It drops in the cycle after a bundle is accepted and returns in the cycle after the final body byte is sent.
- R9: After reset, `out_valid` and `pl_ready` are 0 and `hdr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_valid | input | 1 | Header bundle offered |
| hdr_ready | output | 1 | Bundle can be accepted (idle) |
| hdr_vld | input | 5 | Presence flags, bit 0 Ethernet to bit 4 UDP |
| eth_hdr | input | 112 | Ethernet header, first byte in bits [111:104] |
| mpls_hdr | input | 32 | MPLS label entry, first byte in bits [31:24] |
| ipv4_hdr | input | 160 | IPv4 header, first byte in bits [159:152] |
| tcp_hdr | input | 160 | TCP header, first byte in bits [159:152] |
| udp_hdr | input | 64 | UDP header, first byte in bits [63:56] |
| pl_valid | input | 1 | Body byte offered |
| pl_ready | output | 1 | Body byte taken this cycle |
| pl_data | input | 8 | Body byte |
| pl_last | input | 1 | Final body byte of the packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
The assertions assume two things about the inputs. First, every packet has at least one body byte, so the packet ends with `pl_last`. Second, the body source holds `pl_valid`, `pl_data` and `pl_last` steady until they are taken. The output-hold property relies on this, because body bytes pass straight through to the output. The stimulus follows both rules. It offers each body byte and keeps it unchanged until the handshake, and it gives every packet one to four body bytes. It also offers body bytes early, while headers are still going out, which tests that no body byte is consumed too soon. The bench sweeps all 32 presence patterns twice, first with a free-running sink and then with irregular sink stalls and body-source gaps.

// File: rtl/hdrdp_pkg.sv
// Package: header sizes, byte offsets in the stored bundle, and the
// controller state type shared by the deparser modules.
// Assumes the five headers are stored back to back in emission order.
package hdrdp_pkg;

    localparam int NUM_HDR = 5;
    localparam int ETH_B   = 14;
    localparam int MPLS_B  = 4;
    localparam int IP4_B   = 20;
    localparam int TCP_B   = 20;
    localparam int UDP_B   = 8;
    localparam int TOTAL_B = ETH_B + MPLS_B + IP4_B + TCP_B + UDP_B;
    localparam int MAX_B   = 20;

    localparam int IDX_W  = $clog2(NUM_HDR + 1);
    localparam int BYTE_W = $clog2(MAX_B);
    localparam int POS_W  = $clog2(TOTAL_B);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2
    } dp_state_e;

    // Length in bytes of header slot h (0 = first on the wire).
    function automatic int hdr_len(int h);
        case (h)
            0:       return ETH_B;
            1:       return MPLS_B;
            2:       return IP4_B;
            3:       return TCP_B;
            4:       return UDP_B;
            default: return 1;
        endcase
    endfunction

    // Byte offset of header slot h inside the stored bundle.
    function automatic int hdr_off(int h);
        case (h)
            0:       return 0;
            1:       return ETH_B;
            2:       return ETH_B + MPLS_B;
            3:       return ETH_B + MPLS_B + IP4_B;
            4:       return ETH_B + MPLS_B + IP4_B + TCP_B;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/hdrdp_next_sel.sv
// Next-header search: finds the lowest-numbered flagged slot at or after
// a start index. Purely combinational. A start index beyond the last
// slot yields found = 0.
module hdrdp_next_sel #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] from,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top down so the lowest qualifying slot wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (IW'(i) >= from)) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/hdrdp_hdr_store.sv
// Header store: captures the whole bundle when a packet is accepted and
// returns one byte by position. Position 0 is the most significant byte
// of the flat vector. Assumes rd_pos stays below TOTAL_B while in use.
module hdrdp_hdr_store #(
    parameter int TOTAL_B = 66,
    parameter int POS_W   = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [TOTAL_B*8-1:0] flat_in,
    input  logic [POS_W-1:0]     rd_pos,
    output logic [7:0]           rd_byte
);

    logic [TOTAL_B*8-1:0] flat_q;

    // Hold the bundle for the duration of the packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flat_q <= '0;
        else if (load)
            flat_q <= flat_in;
    end

    // Pick the addressed byte, first-on-wire at the top of the vector.
    always_comb begin
        rd_byte = 8'h00;
        if (int'(rd_pos) < TOTAL_B)
            rd_byte = flat_q[(TOTAL_B - 1 - int'(rd_pos)) * 8 +: 8];
    end

endmodule

// File: rtl/hdrdp_ctrl.sv
// Deparser controller: walks the flagged headers in slot order, one byte
// per output handshake, then passes the body stream through until its
// final byte. Assumes the body stream ends each packet with pl_last.
module hdrdp_ctrl
    import hdrdp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hdr_valid,
    output logic               hdr_ready,
    input  logic [NUM_HDR-1:0] mask_in,
    input  logic               pl_valid,
    input  logic               pl_last,
    output logic               pl_ready,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_last,
    output logic               sel_pay,
    output logic               hdr_load,
    output logic [POS_W-1:0]   rd_pos
);

    dp_state_e          state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [BYTE_W-1:0]  byte_q;
    logic [NUM_HDR-1:0] mask_q;

    logic               accept;
    logic               hdr_end;
    logic [NUM_HDR-1:0] sel_mask;
    logic [IDX_W-1:0]   sel_from;
    logic               nxt_found;
    logic [IDX_W-1:0]   nxt_idx;

    // Handshake and output qualifiers derived from the current state.
    always_comb begin
        hdr_ready = (state_q == ST_IDLE);
        accept    = hdr_valid && hdr_ready;
        out_valid = (state_q == ST_HDR) || ((state_q == ST_PAY) && pl_valid);
        pl_ready  = (state_q == ST_PAY) && out_ready;
        out_last  = (state_q == ST_PAY) && pl_last;
        sel_pay   = (state_q == ST_PAY);
        hdr_load  = accept;
    end

    // Search input: fresh flags from the first slot when idle, otherwise
    // the stored flags from the slot after the current one.
    always_comb begin
        if (state_q == ST_IDLE) begin
            sel_mask = mask_in;
            sel_from = '0;
        end else begin
            sel_mask = mask_q;
            sel_from = idx_q + IW_ONE;
        end
    end

    localparam logic [IDX_W-1:0] IW_ONE = IDX_W'(1);

    // Last byte of the current header and its read position.
    always_comb begin
        hdr_end = (byte_q == BYTE_W'(hdr_len(int'(idx_q)) - 1));
        rd_pos  = POS_W'(hdr_off(int'(idx_q)) + int'(byte_q));
    end

    hdrdp_next_sel #(
        .N  (NUM_HDR),
        .IW (IDX_W)
    ) next_sel_i (
        .mask  (sel_mask),
        .from  (sel_from),
        .found (nxt_found),
        .idx   (nxt_idx)
    );

    // Packet sequencing: idle, header bytes, body pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            byte_q  <= '0;
            mask_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        mask_q <= mask_in;
                        byte_q <= '0;
                        if (nxt_found) begin
                            idx_q   <= nxt_idx;
                            state_q <= ST_HDR;
                        end else begin
                            state_q <= ST_PAY;
                        end
                    end
                end
                ST_HDR: begin
                    if (out_ready) begin
                        if (hdr_end) begin
                            byte_q <= '0;
                            if (nxt_found)
                                idx_q <= nxt_idx;
                            else
                                state_q <= ST_PAY;
                        end else begin
                            byte_q <= byte_q + BYTE_W'(1);
                        end
                    end
                end
                ST_PAY: begin
                    if (pl_valid && out_ready && pl_last)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hdr_deparser.sv
// Top of the header deparser: packs the five header buses into one
// store in emission order, runs the controller, and steers either a
// stored header byte or the body byte onto the output.
// Assumes one bundle per packet and at least one body byte per packet.
module hdr_deparser
    import hdrdp_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hdr_valid,
    output logic         hdr_ready,
    input  logic [4:0]   hdr_vld,
    input  logic [111:0] eth_hdr,
    input  logic [31:0]  mpls_hdr,
    input  logic [159:0] ipv4_hdr,
    input  logic [159:0] tcp_hdr,
    input  logic [63:0]  udp_hdr,
    input  logic         pl_valid,
    output logic         pl_ready,
    input  logic [7:0]   pl_data,
    input  logic         pl_last,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [7:0]   out_data,
    output logic         out_last
);

    logic [TOTAL_B*8-1:0] flat;
    logic                 sel_pay;
    logic                 hdr_load;
    logic [POS_W-1:0]     rd_pos;
    logic [7:0]           hdr_byte;

    // Bundle in wire order: Ethernet occupies the top bytes.
    always_comb flat = {eth_hdr, mpls_hdr, ipv4_hdr, tcp_hdr, udp_hdr};

    hdrdp_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (hdr_valid),
        .hdr_ready (hdr_ready),
        .mask_in   (hdr_vld),
        .pl_valid  (pl_valid),
        .pl_last   (pl_last),
        .pl_ready  (pl_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_last  (out_last),
        .sel_pay   (sel_pay),
        .hdr_load  (hdr_load),
        .rd_pos    (rd_pos)
    );

    hdrdp_hdr_store #(
        .TOTAL_B (TOTAL_B),
        .POS_W   (POS_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (hdr_load),
        .flat_in (flat),
        .rd_pos  (rd_pos),
        .rd_byte (hdr_byte)
    );

    // Output byte source: body during pass-through, header store otherwise.
    always_comb out_data = sel_pay ? pl_data : hdr_byte;

endmodule

// File: rtl/hdr_deparser_chk.sv
// Checker for the header deparser, bound to the top. It counts header
// bytes sent before the first body byte and compares the count with the
// flagged lengths. It assumes the body source holds its byte until taken.
module hdr_deparser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hdr_valid,
    input logic       hdr_ready,
    input logic [4:0] hdr_vld,
    input logic       pl_valid,
    input logic       pl_ready,
    input logic       pl_last,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last
);

    logic       in_pkt_q;
    logic       pay_seen_q;
    logic [7:0] hcnt_q;
    logic [7:0] exp_q;

    // Summed header length for a set of presence flags.
    function automatic logic [7:0] flagged_len(logic [4:0] m);
        int s;
        s = 0;
        if (m[0]) s += 14;
        if (m[1]) s += 4;
        if (m[2]) s += 20;
        if (m[3]) s += 20;
        if (m[4]) s += 8;
        return 8'(s);
    endfunction

    // Track header bytes sent since the bundle was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt_q   <= 1'b0;
            pay_seen_q <= 1'b0;
            hcnt_q     <= '0;
            exp_q      <= '0;
        end else if (hdr_valid && hdr_ready) begin
            in_pkt_q   <= 1'b1;
            pay_seen_q <= 1'b0;
            hcnt_q     <= '0;
            exp_q      <= flagged_len(hdr_vld);
        end else begin
            if (out_valid && out_ready && !(pl_valid && pl_ready) && !pay_seen_q)
                hcnt_q <= hcnt_q + 8'd1;
            if (pl_valid && pl_ready)
                pay_seen_q <= 1'b1;
            if (pl_valid && pl_ready && pl_last)
                in_pkt_q <= 1'b0;
        end
    end

    AST_HDR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pkt_q && !pay_seen_q && pl_valid && pl_ready) |-> (hcnt_q == exp_q)); // R2

    AST_NO_EARLY_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pkt_q && !pay_seen_q && (hcnt_q < exp_q)) |-> !pl_ready); // R4

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R6

    AST_BODY_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && pl_ready) |-> (out_valid && out_ready)); // R6

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> !hdr_ready); // R8

    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> hdr_ready); // R8

endmodule

bind hdr_deparser hdr_deparser_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .hdr_ready (hdr_ready),
    .hdr_vld   (hdr_vld),
    .pl_valid  (pl_valid),
    .pl_ready  (pl_ready),
    .pl_last   (pl_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/hdr_deparser_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps all 32 presence patterns, first with a free sink and then
// with sink stalls and body gaps, and compares the full output stream
// with a stream built arithmetically from the requirements.
module hdr_deparser_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hdr_valid = 1'b0;
    logic         hdr_ready;
    logic [4:0]   hdr_vld = '0;
    logic [111:0] eth_hdr = '0;
    logic [31:0]  mpls_hdr = '0;
    logic [159:0] ipv4_hdr = '0;
    logic [159:0] tcp_hdr = '0;
    logic [63:0]  udp_hdr = '0;
    logic         pl_valid = 1'b0;
    logic         pl_ready;
    logic [7:0]   pl_data = '0;
    logic         pl_last = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [7:0]   out_data;
    logic         out_last;

    int   checks = 0;
    int   errors = 0;
    int   cur_m = 0;
    int   cyc = 0;
    bit   finished = 1'b0;
    bit   mon_en = 1'b0;

    logic [7:0] exp_b [0:127];
    logic [7:0] got_b [0:127];
    logic       got_l [0:127];
    int         exp_n;
    int         hdr_n;
    int         got_n;
    bit         prev_stall = 1'b0;
    logic [7:0] prev_data = '0;

    always #2.5 clk = ~clk;

    hdr_deparser dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (hdr_valid),
        .hdr_ready (hdr_ready),
        .hdr_vld   (hdr_vld),
        .eth_hdr   (eth_hdr),
        .mpls_hdr  (mpls_hdr),
        .ipv4_hdr  (ipv4_hdr),
        .tcp_hdr   (tcp_hdr),
        .udp_hdr   (udp_hdr),
        .pl_valid  (pl_valid),
        .pl_ready  (pl_ready),
        .pl_data   (pl_data),
        .pl_last   (pl_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    task automatic chk(input string tag, input bit ok, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s mask=%0d got=%0h exp=%0h", tag, cur_m, got, exp);
        end
    endtask

    function automatic int hlen(int h);
        case (h)
            0: return 14;
            1: return 4;
            2: return 20;
            3: return 20;
            default: return 8;
        endcase
    endfunction

    function automatic logic [7:0] hb(int h, int k, int m);
        return 8'((h * 41 + k * 7 + m * 3 + 1) % 256);
    endfunction

    function automatic logic [7:0] pb(int m, int i);
        return 8'((200 + m * 5 + i * 13) % 256);
    endfunction

    // Output monitor, sampled mid-cycle; also checks stall stability (R6).
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (prev_stall) begin
                chk("R6", out_valid == 1'b1, int'(out_valid), 1);
                chk("R6", out_data == prev_data, int'(out_data), int'(prev_data));
            end
            if (out_valid && out_ready && got_n < 128) begin
                got_b[got_n] = out_data;
                got_l[got_n] = out_last;
                got_n++;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic run_pkt(input int m, input bit bp);
        int  npl;
        int  pi;
        bit  done;
        bit  hsh;
        bit  hsp;
        bit  chk_busy;
        cur_m = m;
        exp_n = 0;
        for (int h = 0; h < 5; h++)
            if (m[h])
                for (int k = 0; k < hlen(h); k++) begin
                    exp_b[exp_n] = hb(h, k, m);
                    exp_n++;
                end
        hdr_n = exp_n;
        npl = (m % 4) + 1;
        for (int i = 0; i < npl; i++) begin
            exp_b[exp_n] = pb(m, i);
            exp_n++;
        end
        for (int k = 0; k < 14; k++) eth_hdr[(13 - k) * 8 +: 8]  = hb(0, k, m);
        for (int k = 0; k < 4; k++)  mpls_hdr[(3 - k) * 8 +: 8]  = hb(1, k, m);
        for (int k = 0; k < 20; k++) ipv4_hdr[(19 - k) * 8 +: 8] = hb(2, k, m);
        for (int k = 0; k < 20; k++) tcp_hdr[(19 - k) * 8 +: 8]  = hb(3, k, m);
        for (int k = 0; k < 8; k++)  udp_hdr[(7 - k) * 8 +: 8]   = hb(4, k, m);
        hdr_vld   = 5'(m);
        hdr_valid = 1'b1;
        got_n     = 0;
        pi        = 0;
        done      = 1'b0;
        chk_busy  = 1'b0;
        while (!done) begin
            out_ready = bp ? (((cyc * 3 + m) % 4) != 0) : 1'b1;
            if (!pl_valid && pi < npl) begin
                pl_valid = bp ? ((cyc % 3) != 1) : 1'b1;
                pl_data  = pb(m, pi);
                pl_last  = (pi == npl - 1);
            end
            @(negedge clk);
            if (chk_busy) begin
                chk("R8", hdr_ready == 1'b0, int'(hdr_ready), 0);
                chk_busy = 1'b0;
            end
            hsh = hdr_valid && hdr_ready;
            hsp = pl_valid && pl_ready;
            @(posedge clk);
            #1;
            cyc++;
            if (hsh) begin
                hdr_valid = 1'b0;
                chk_busy  = 1'b1;
            end
            if (hsp) begin
                pl_valid = 1'b0;
                pi++;
                if (pi == npl) done = 1'b1;
            end
        end
        out_ready = 1'b0;
        @(negedge clk);
        chk("R8", hdr_ready == 1'b1, int'(hdr_ready), 1);
        chk("R2", got_n == exp_n, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            if (m == 0)
                chk("R5", got_b[i] == exp_b[i], int'(got_b[i]), int'(exp_b[i]));
            else if (i >= hdr_n)
                chk("R4", got_b[i] == exp_b[i], int'(got_b[i]), int'(exp_b[i]));
            else if (m[3] && m[4])
                chk("R7", got_b[i] == exp_b[i], int'(got_b[i]), int'(exp_b[i]));
            else if ($countones(m) > 1)
                chk("R1", got_b[i] == exp_b[i], int'(got_b[i]), int'(exp_b[i]));
            else
                chk("R3", got_b[i] == exp_b[i], int'(got_b[i]), int'(exp_b[i]));
            chk("R4", got_l[i] == (i == exp_n - 1), int'(got_l[i]), int'(i == exp_n - 1));
        end
        @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog expired got=0 exp=1");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Main sequence: reset check, then both sweeps.
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R9", out_valid == 1'b0, int'(out_valid), 0);
        chk("R9", pl_ready == 1'b0, int'(pl_ready), 0);
        chk("R9", hdr_ready == 1'b1, int'(hdr_ready), 1);
        @(posedge clk);
        #1;
        rst_n  = 1'b1;
        mon_en = 1'b1;
        for (int pass = 0; pass < 2; pass++)
            for (int m = 0; m < 32; m++)
                run_pkt(m, pass[0]);
        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule